// File: doc/BRIEF.md
# Pipelined Late-Write Burst SRAM

This block models a synchronous single-port memory for a host that issues one command per clock. Every command input is registered on the rising clock edge: the start address, a primary active-low select, two bank-select inputs with their own level-select straps, a burst-continue flag, an active-low write enable and one active-low enable per data lane. Reads are pipelined, so their data appears one cycle after the command. Writes are late, so their data is taken on the edge one cycle after the command.

A new command loads an address. A continue cycle repeats the previous operation and steps the two low address bits, so one base address covers up to four beats before it wraps. The bank-select straps let up to four devices share a bus with no glue logic. Deselecting through them turns off both the read-data enable and the echo-clock enable. Deselecting through the primary select turns off only the data. Output drivers are modelled as enable signals.

Top module: `plw_burst_sram`

## Requirements
- R1: A read command (burst_cont_i=0, cs_n_i=0, banks matched, we_n_i=1) registered on edge k makes rd_valid_o=1 after edge k+1, and rd_data_o then holds the word at the command address.
- R2: A write command registered on edge k stores the wr_data_i value that is present at edge k+1. The value present at edge k is not stored.
- R3: The bank match is true only when bank_sel_a_i equals bank_lvl_a_i and bank_sel_b_i equals bank_lvl_b_i. A new command with no bank match is a bank deselect, whatever cs_n_i and we_n_i are.
- R4: A new command with a bank match and cs_n_i=1 is a plain deselect. echo_en_o stays 1 after it.
- R5: After a bank deselect is registered on edge k, echo_en_o is 0 from edge k+1.
- R6: After a plain deselect, a bank deselect or a write is registered on edge k, rd_valid_o is 0 from edge k+1.
- R7: A continue cycle (burst_cont_i=1) after a read or a write repeats that operation at the address whose low two bits are increased by one modulo 4. The upper bits do not change. The fourth continue returns to the base address.
- R8: A continue cycle after either kind of deselect keeps that deselect, with the same output enables.
- R9: During a write beat, lane g, which is wr_data_i bits [g*LANE +: LANE], is stored only when lane_en_n_i[g]=0 in that beat's command cycle. With all lane enables at 1 nothing is stored, but the burst address still steps.
- R10: A read that immediately follows a write to the same address returns the newly written lanes merged with the lanes left unchanged.
- R11: While rst_n is low and after it is released, rd_valid_o=0 and echo_en_o=0, and the block is bank-deselected until a new command arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all inputs sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | AW | Start address of a new command |
| cs_n_i | input | 1 | Primary select, active low |
| bank_sel_a_i | input | 1 | Bank select input A |
| bank_sel_b_i | input | 1 | Bank select input B |
| bank_lvl_a_i | input | 1 | Static level that bank_sel_a_i must match |
| bank_lvl_b_i | input | 1 | Static level that bank_sel_b_i must match |
| burst_cont_i | input | 1 | 0 = new command, 1 = continue the current one |
| we_n_i | input | 1 | 0 = write, 1 = read, for new commands |
| lane_en_n_i | input | NB | Active-low lane write enables for this beat |
| wr_data_i | input | DW | Write data, taken one cycle after its beat |
| rd_data_o | output | DW | Read data, one cycle after its beat |
| rd_valid_o | output | 1 | Data output enable (0 = high impedance) |
| echo_en_o | output | 1 | Echo clock enable (0 = high impedance) |

## Verification
The bench checks the two deselect paths against each other: a design that treats a bank deselect like a plain one would keep echo_en_o high. It also checks that a write request with no bank match is dropped even when cs_n_i=0. Bursts run past four beats so that a counter carrying into the upper address bits reads or writes the wrong block, and an all-ones lane mask in the middle of a burst shows whether an aborted beat corrupts memory or stalls the address. A read placed right behind a write, and a write whose data changes between the command cycle and the data cycle, expose a design that samples write data on the wrong edge or reads stale memory.

// File: rtl/plw_pkg.sv
package plw_pkg;

  typedef enum logic [1:0] {
    OP_BDESEL = 2'd0,
    OP_DESEL  = 2'd1,
    OP_READ   = 2'd2,
    OP_WRITE  = 2'd3
  } plw_op_e;

  // next beat offset inside a four-beat block: wraps modulo four
  function automatic logic [1:0] burst_next(input logic [1:0] ofs);
    return 2'(ofs + 2'd1);
  endfunction

endpackage

// File: rtl/plw_cmd_decode.sv
module plw_cmd_decode
  import plw_pkg::*;
(
  input  logic    cs_n,
  input  logic    sel_a,
  input  logic    sel_b,
  input  logic    lvl_a,
  input  logic    lvl_b,
  input  logic    cont,
  input  logic    we_n,
  input  plw_op_e cur_op,
  output plw_op_e nxt_op,
  output logic    load,
  output logic    step
);

  logic bank_match;
  assign bank_match = (sel_a == lvl_a) && (sel_b == lvl_b);

  always_comb begin
    nxt_op = cur_op;
    load   = 1'b0;
    step   = 1'b0;
    if (!cont) begin
      if (!bank_match)   nxt_op = OP_BDESEL;
      else if (cs_n)     nxt_op = OP_DESEL;
      else begin
        nxt_op = we_n ? OP_READ : OP_WRITE;
        load   = 1'b1;
      end
    end else if (cur_op == OP_READ || cur_op == OP_WRITE) begin
      step = 1'b1;
    end
  end

endmodule

// File: rtl/plw_addr_ctr.sv
module plw_addr_ctr
  import plw_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] base,
  output logic [AW-1:0] addr
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    addr <= '0;
    else if (load) addr <= base;
    else if (step) addr <= {addr[AW-1:2], burst_next(addr[1:0])};
  end

endmodule

// File: rtl/plw_mem_array.sv
module plw_mem_array #(
  parameter int AW = 6,
  parameter int DW = 36,
  parameter int NB = 4
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [NB-1:0] lane_en_n,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rd_en,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int LANE  = DW / NB;
  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic [LANE-1:0] store [DEPTH];
    logic [LANE-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (wr_en && !lane_en_n[g]) store[waddr] <= wdata[g*LANE +: LANE];
      if (rd_en)                  rd_q         <= store[raddr];
    end

    assign rdata[g*LANE +: LANE] = rd_q;
  end

endmodule

// File: rtl/plw_burst_sram.sv
module plw_burst_sram
  import plw_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 36,
  parameter int NB = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr_i,
  input  logic          cs_n_i,
  input  logic          bank_sel_a_i,
  input  logic          bank_sel_b_i,
  input  logic          bank_lvl_a_i,
  input  logic          bank_lvl_b_i,
  input  logic          burst_cont_i,
  input  logic          we_n_i,
  input  logic [NB-1:0] lane_en_n_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [DW-1:0] rd_data_o,
  output logic          rd_valid_o,
  output logic          echo_en_o
);

  plw_op_e       op_q, op_nxt;
  logic          cmd_load, burst_step;
  logic [AW-1:0] cur_addr;
  logic [NB-1:0] lane_en_q;
  logic          wr_commit, rd_issue;
  logic          rd_valid_q, echo_en_q;

  plw_cmd_decode u_dec (
    .cs_n   (cs_n_i),
    .sel_a  (bank_sel_a_i),
    .sel_b  (bank_sel_b_i),
    .lvl_a  (bank_lvl_a_i),
    .lvl_b  (bank_lvl_b_i),
    .cont   (burst_cont_i),
    .we_n   (we_n_i),
    .cur_op (op_q),
    .nxt_op (op_nxt),
    .load   (cmd_load),
    .step   (burst_step)
  );

  plw_addr_ctr #(.AW(AW)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (cmd_load),
    .step  (burst_step),
    .base  (addr_i),
    .addr  (cur_addr)
  );

  // command state of the beat whose data phase is the coming cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q      <= OP_BDESEL;
      lane_en_q <= '1;
    end else begin
      op_q      <= op_nxt;
      lane_en_q <= lane_en_n_i;
    end
  end

  assign wr_commit = (op_q == OP_WRITE) && !(&lane_en_q);
  assign rd_issue  = (op_q == OP_READ);

  plw_mem_array #(.AW(AW), .DW(DW), .NB(NB)) u_mem (
    .clk       (clk),
    .wr_en     (wr_commit),
    .lane_en_n (lane_en_q),
    .waddr     (cur_addr),
    .wdata     (wr_data_i),
    .rd_en     (rd_issue),
    .raddr     (cur_addr),
    .rdata     (rd_data_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      echo_en_q  <= 1'b0;
    end else begin
      rd_valid_q <= rd_issue;
      echo_en_q  <= (op_q != OP_BDESEL);
    end
  end

  assign rd_valid_o = rd_valid_q;
  assign echo_en_o  = echo_en_q;

endmodule

// File: rtl/plw_burst_sram_chk.sv
module plw_burst_sram_chk #(
  parameter int AW = 6,
  parameter int NB = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n_i,
  input logic          bank_sel_a_i,
  input logic          bank_sel_b_i,
  input logic          bank_lvl_a_i,
  input logic          bank_lvl_b_i,
  input logic          burst_cont_i,
  input logic          we_n_i,
  input logic [NB-1:0] lane_en_n_i,
  input logic          rd_valid_o,
  input logic          echo_en_o,
  input logic          burst_step,
  input logic [AW-1:0] cur_addr,
  input logic          wr_commit
);

  logic match_c, new_cmd;
  assign match_c = (bank_sel_a_i == bank_lvl_a_i) && (bank_sel_b_i == bank_lvl_b_i);
  assign new_cmd = !burst_cont_i;

  assert_read_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (new_cmd && match_c && !cs_n_i && we_n_i) |=> ##1 rd_valid_o);

  assert_plain_desel_echo_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (new_cmd && match_c && cs_n_i) |=> ##1 echo_en_o);

  assert_bank_desel_echo_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (new_cmd && !match_c) |=> ##1 !echo_en_o);

  assert_write_no_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (new_cmd && match_c && !cs_n_i && !we_n_i) |=> ##1 !rd_valid_o);

  assert_burst_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    burst_step |=> (cur_addr[AW-1:2] == $past(cur_addr[AW-1:2])) &&
                   (cur_addr[1:0] == 2'($past(cur_addr[1:0]) + 2'd1)));

  assert_abort_no_store_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> ($past(lane_en_n_i) != {NB{1'b1}}));

endmodule

bind plw_burst_sram plw_burst_sram_chk #(.AW(AW), .NB(NB)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cs_n_i       (cs_n_i),
  .bank_sel_a_i (bank_sel_a_i),
  .bank_sel_b_i (bank_sel_b_i),
  .bank_lvl_a_i (bank_lvl_a_i),
  .bank_lvl_b_i (bank_lvl_b_i),
  .burst_cont_i (burst_cont_i),
  .we_n_i       (we_n_i),
  .lane_en_n_i  (lane_en_n_i),
  .rd_valid_o   (rd_valid_o),
  .echo_en_o    (echo_en_o),
  .burst_step   (burst_step),
  .cur_addr     (cur_addr),
  .wr_commit    (wr_commit)
);

// File: tb/plw_burst_sram_bench.sv
`timescale 1ns/1ps
module plw_burst_sram_bench;
  localparam int AW = 6;
  localparam int DW = 36;
  localparam int NB = 4;
  localparam int LANE = DW / NB;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          cs_n_i = 1'b1;
  logic          bank_sel_a_i = 1'b0;
  logic          bank_sel_b_i = 1'b0;
  logic          bank_lvl_a_i = 1'b1;
  logic          bank_lvl_b_i = 1'b0;
  logic          burst_cont_i = 1'b1;
  logic          we_n_i = 1'b1;
  logic [NB-1:0] lane_en_n_i = '1;
  logic [DW-1:0] wr_data_i = '0;
  logic [DW-1:0] rd_data_o;
  logic          rd_valid_o;
  logic          echo_en_o;

  always #2 clk = ~clk;

  plw_burst_sram #(.AW(AW), .DW(DW), .NB(NB)) u_plw_burst_sram (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .cs_n_i(cs_n_i),
    .bank_sel_a_i(bank_sel_a_i), .bank_sel_b_i(bank_sel_b_i),
    .bank_lvl_a_i(bank_lvl_a_i), .bank_lvl_b_i(bank_lvl_b_i),
    .burst_cont_i(burst_cont_i), .we_n_i(we_n_i), .lane_en_n_i(lane_en_n_i),
    .wr_data_i(wr_data_i), .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o),
    .echo_en_o(echo_en_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // reference model: 0 bank deselect, 1 deselect, 2 read, 3 write
  logic [DW-1:0] ref_mem [DEPTH];
  int            ref_op = 0;
  logic [AW-1:0] ref_addr = '0;
  logic [NB-1:0] ref_lanes = '1;

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int s);
    logic [63:0] t;
    t = 64'h9E37_79B9_7F4A_7C15 * 64'(s + 1);
    return t[DW-1:0] ^ t[63:64-DW];
  endfunction

  function automatic logic [DW-1:0] lane_merge(input logic [DW-1:0] old_w,
                                               input logic [DW-1:0] new_w,
                                               input logic [NB-1:0] en_n);
    logic [DW-1:0] r;
    r = old_w;
    for (int g = 0; g < NB; g++)
      if (en_n[g] == 1'b0) r[g*LANE +: LANE] = new_w[g*LANE +: LANE];
    return r;
  endfunction

  task automatic drive(input logic cont, input logic wn, input logic csn,
                       input logic sa, input logic sb, input logic [AW-1:0] a,
                       input logic [NB-1:0] ln, input logic [DW-1:0] d);
    burst_cont_i = cont; we_n_i = wn; cs_n_i = csn;
    bank_sel_a_i = sa; bank_sel_b_i = sb; addr_i = a;
    lane_en_n_i = ln; wr_data_i = d;
  endtask

  // one clock: model predicts, edge happens, outputs compared
  task automatic tick();
    logic exp_v, exp_e, match;
    logic [DW-1:0] exp_d;
    exp_v = (ref_op == 2);
    exp_e = (ref_op != 0);
    exp_d = ref_mem[ref_addr];
    if (ref_op == 3) ref_mem[ref_addr] = lane_merge(ref_mem[ref_addr], wr_data_i, ref_lanes);
    match = (bank_sel_a_i == bank_lvl_a_i) && (bank_sel_b_i == bank_lvl_b_i);
    if (!burst_cont_i) begin
      if (!match)      ref_op = 0;
      else if (cs_n_i) ref_op = 1;
      else begin
        ref_op = we_n_i ? 2 : 3;
        ref_addr = addr_i;
      end
    end else if (ref_op >= 2) begin
      ref_addr[1:0] = ref_addr[1:0] + 2'd1;
    end
    ref_lanes = lane_en_n_i;
    @(posedge clk);
    #1;
    check("R6 valid", {{(DW-1){1'b0}}, rd_valid_o}, {{(DW-1){1'b0}}, exp_v});
    check("R5 echo", {{(DW-1){1'b0}}, echo_en_o}, {{(DW-1){1'b0}}, exp_e});
    if (exp_v) check("R1 data", rd_data_o, exp_d);
  endtask

  task automatic model_reset();
    ref_op = 0;
    ref_addr = '0;
    ref_lanes = '1;
  endtask

  // table: cont, we_n, cs_n, sel_a, sel_b, addr, lane_en_n, data sel, exp valid, exp echo
  localparam int NV = 22;
  localparam logic [19:0] VEC [NV] = '{
    {1'b0,1'b0,1'b0,1'b1,1'b0,6'd4,4'b0000,3'd0,1'b0,1'b0},
    {1'b1,1'b1,1'b1,1'b1,1'b0,6'd0,4'b0000,3'd1,1'b0,1'b1},
    {1'b1,1'b1,1'b1,1'b1,1'b0,6'd0,4'b0101,3'd2,1'b0,1'b1},
    {1'b1,1'b1,1'b1,1'b1,1'b0,6'd0,4'b1111,3'd3,1'b0,1'b1},
    {1'b1,1'b1,1'b1,1'b1,1'b0,6'd0,4'b0000,3'd4,1'b0,1'b1},
    {1'b0,1'b1,1'b1,1'b1,1'b0,6'd0,4'b1111,3'd5,1'b0,1'b1},
    {1'b0,1'b1,1'b0,1'b1,1'b0,6'd4,4'b1111,3'd0,1'b0,1'b1},
    {1'b1,1'b1,1'b1,1'b1,1'b0,6'd0,4'b1111,3'd0,1'b1,1'b1},
    {1'b1,1'b1,1'b1,1'b1,1'b0,6'd0,4'b1111,3'd0,1'b1,1'b1},
    {1'b1,1'b1,1'b1,1'b1,1'b0,6'd0,4'b1111,3'd0,1'b1,1'b1},
    {1'b1,1'b1,1'b1,1'b1,1'b0,6'd0,4'b1111,3'd0,1'b1,1'b1},
    {1'b0,1'b1,1'b0,1'b0,1'b0,6'd0,4'b1111,3'd0,1'b1,1'b1},
    {1'b1,1'b1,1'b1,1'b1,1'b0,6'd0,4'b1111,3'd0,1'b0,1'b0},
    {1'b0,1'b0,1'b0,1'b1,1'b1,6'd9,4'b0000,3'd0,1'b0,1'b0},
    {1'b0,1'b0,1'b0,1'b1,1'b0,6'd9,4'b1110,3'd0,1'b0,1'b0},
    {1'b0,1'b1,1'b0,1'b1,1'b0,6'd9,4'b1111,3'd6,1'b0,1'b1},
    {1'b0,1'b1,1'b1,1'b1,1'b0,6'd0,4'b1111,3'd0,1'b1,1'b1},
    {1'b1,1'b1,1'b1,1'b1,1'b0,6'd0,4'b1111,3'd0,1'b0,1'b1},
    {1'b1,1'b1,1'b1,1'b1,1'b0,6'd0,4'b1111,3'd0,1'b0,1'b1},
    {1'b0,1'b1,1'b0,1'b1,1'b0,6'd6,4'b1111,3'd0,1'b0,1'b1},
    {1'b0,1'b1,1'b1,1'b1,1'b0,6'd0,4'b1111,3'd0,1'b1,1'b1},
    {1'b0,1'b1,1'b0,1'b0,1'b0,6'd0,4'b1111,3'd0,1'b0,1'b1}
  };

  function automatic string row_req(input int i);
    case (i)
      0, 1, 2, 3, 4:       return "R9 lanes";
      5:                   return "R2 late data";
      6:                   return "R4 plain deselect";
      7, 8, 9, 10, 11:     return "R7 burst wrap";
      12:                  return "R5 bank deselect";
      13:                  return "R3 bank match";
      14, 15, 16:          return "R10 coherence";
      17, 18:              return "R8 continue deselect";
      default:             return "R9 partial lanes";
    endcase
  endfunction

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d_a, d_b;
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    // R11: outputs off while held in reset
    check("R11 reset valid", {{(DW-1){1'b0}}, rd_valid_o}, '0);
    check("R11 reset echo", {{(DW-1){1'b0}}, echo_en_o}, '0);
    rst_n = 1'b1;
    drive(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, '0, '1, '0);
    tick();   // R11: continue after reset stays bank-deselected

    // preload every word with full-lane four-beat bursts
    for (int i = 0; i < DEPTH; i++) begin
      drive((i % 4) != 0, 1'b0, 1'b0, 1'b1, 1'b0, AW'(i), 4'b0000, pat(i + 500));
      tick();
    end
    drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, '0, '1, pat(1000));
    tick();

    // vector table walk
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][19], VEC[i][18], VEC[i][17], VEC[i][16], VEC[i][15],
            VEC[i][14:9], VEC[i][8:5], pat(200 + int'(VEC[i][4:2])));
      tick();
      check(row_req(i), {{(DW-2){1'b0}}, rd_valid_o, echo_en_o},
            {{(DW-2){1'b0}}, VEC[i][1], VEC[i][0]});
    end

    // R2: data present in the command cycle must not be the one stored
    d_a = pat(7001);
    d_b = pat(7002);
    drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 6'd20, 4'b0000, d_a);
    tick();
    drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, '0, '1, d_b);
    tick();
    drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 6'd20, '1, d_a);
    tick();
    drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, '0, '1, d_a);
    tick();
    check("R2 late write data", rd_data_o, d_b);

    // R9: aborted beat leaves the word intact, burst still steps to addr 21
    drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 6'd20, 4'b1111, '0);
    tick();
    drive(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, '0, 4'b0000, pat(7100));
    tick();
    drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 6'd20, '1, pat(7003));
    tick();
    drive(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, '0, '1, '0);
    tick();
    check("R9 abort kept word", rd_data_o, d_b);
    drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, '0, '1, '0);
    tick();
    check("R9 abort still stepped", rd_data_o, pat(7003));

    // R11: reset in the middle of a read burst
    drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 6'd8, '1, '0);
    tick();
    drive(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, '0, '1, '0);
    tick();
    rst_n = 1'b0;
    #1;
    check("R11 mid-burst reset valid", {{(DW-1){1'b0}}, rd_valid_o}, '0);
    check("R11 mid-burst reset echo", {{(DW-1){1'b0}}, echo_en_o}, '0);
    model_reset();
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    tick();
    tick();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule